// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial port for a bank of byte-wide configuration registers. A host opens a transaction by pulling an active-low select line low. It then clocks in a 16-bit frame on one data pin, most significant bit first: a 4-bit command in the top bits, a 4-bit register address next, and a data byte in the low bits. A write command stores the byte in the addressed register. A read command turns the data pin around: the block drives the addressed register's byte back to the host, and repeats it for every further group of eight serial clocks until select is released.

The serial select, clock and data inputs are brought through a short synchronizer into the block's system clock domain, and all state runs on that clock. Input bits are taken on serial clock rising edges. Readback bits change on falling edges, so the host can sample them on the next rising edge. The whole register bank is visible on a flat readback bus, where it drives the functions being configured. The register at address 3 holds the oscillator divisor. It resets to the crystal frequency divided by 100 kHz, rounded to the nearest integer. All other registers reset to zero.

Top module: `sreg_port`

## Requirements
- R1: After reset, every register reads zero except address 3, which holds round(XTAL_KHZ / 100); with the default XTAL_KHZ = 13560 that is 0x88. Register r occupies bits [8r+7:8r] of reg_flat.
- R2: A frame is 16 bits taken MSB first on sclk rising edges while cs_n is low: bits 15..12 command, 11..8 address, 7..0 data. Command 4'b0001 writes the data byte into the addressed register.
- R3: If cs_n rises before the 16th rising edge, the frame is discarded without any register change, and the next frame starts again from bit 15.
- R4: Command 4'b0010 (data field sent as zeros) makes the block drive the addressed register on dio_o, MSB first. A new bit appears after each sclk falling edge, starting with the falling edge that follows the 16th rising edge.
- R5: During a read, the same byte repeats for every further group of eight sclk periods, for as long as cs_n stays low.
- R6: dio_oe is high only in the readback phase. That phase runs from the first falling edge after a read frame until cs_n rises. dio_oe is low during every input bit and while cs_n is high.
- R7: Any command other than 4'b0001 and 4'b0010 changes no register and never asserts dio_oe.
- R8: Serial clocks after the 16th bit of a write frame are ignored: no further register change until cs_n rises.
- R9: Serial clock activity while cs_n is high changes no register and drives nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock from the host |
| dio_i | input | 1 | Data pin input level |
| dio_o | output | 1 | Data pin output value during readback |
| dio_oe | output | 1 | Data pin output-driver enable |
| reg_flat | output | 128 | All registers concatenated, register r at bits [8r+7:8r] |

## Verification
Suppose the bit counter slips or is not cleared by a cut-short frame. The next write then lands on the wrong address or with a shifted byte, and the damage shows on reg_flat within a few system clocks of that frame's 16th rising edge. A wrong readback bit index or a missed repeat appears on dio_o at the first host sample after the faulty falling edge. A turnaround fault, where the driver is on during input or stays on after deselect, shows on dio_oe within one serial half period. Decode faults on unknown or extra-clocked frames appear as reg_flat changes or a stray dio_oe right after the frame.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   localparam logic [3:0] CMD_WRITE = 4'b0001;
   localparam logic [3:0] CMD_READ  = 4'b0010;

   typedef enum logic [1:0] {
      FR_SHIFT = 2'd0,
      FR_READ  = 2'd1,
      FR_DONE  = 2'd2
   } fr_state_t;

   function automatic int unsigned round_div(input int unsigned num, input int unsigned den);
      return (num + den / 2) / den;
   endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sreg_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/sreg_file.sv
module sreg_file #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned OSC_ADDR = 3,
   parameter logic [DATA_W-1:0] OSC_RST = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [DATA_W-1:0]             rd_data,
   output logic [(DATA_W<<ADDR_W)-1:0]   regs_flat
);

   localparam int unsigned NUM_REGS = 1 << ADDR_W;

   generate
      if (OSC_ADDR >= NUM_REGS) begin : g_bad_osc
         $error("oscillator register address outside the bank");
      end
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         localparam logic [DATA_W-1:0] RV = (r == OSC_ADDR) ? OSC_RST : '0;
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= RV;
            end else if (wr_en && (wr_addr == ADDR_W'(r))) begin
               q <= wr_data;
            end
         end
         assign regs_flat[r*DATA_W +: DATA_W] = q;
      end
   endgenerate

   assign rd_data = regs_flat[rd_addr*DATA_W +: DATA_W];

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_flat)); // R7

endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
   import sreg_pkg::*;
#(
   parameter int unsigned CMD_W  = 4,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8,
   parameter logic [CMD_W-1:0] WR_CODE = CMD_WRITE,
   parameter logic [CMD_W-1:0] RD_CODE = CMD_READ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              sclk_lvl,
   input  logic              din,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              dout,
   output logic              doe
);

   localparam int unsigned FRAME_W = CMD_W + ADDR_W + DATA_W;
   localparam int unsigned CNT_W   = $clog2(FRAME_W);
   localparam int unsigned BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   generate
      if (WR_CODE == RD_CODE) begin : g_bad_codes
         $error("write and read codes must differ");
      end
   endgenerate

   fr_state_t          st;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-2:0] shreg;
   logic [BIT_W-1:0]   bit_idx;
   logic               sclk_prev;
   logic               rise, fall, last_bit;
   logic [FRAME_W-1:0] frame_nxt;
   logic [CMD_W-1:0]   f_cmd;
   logic [ADDR_W-1:0]  f_addr;
   logic [DATA_W-1:0]  f_data;

   assign rise      = sclk_lvl & ~sclk_prev;
   assign fall      = ~sclk_lvl & sclk_prev;
   assign frame_nxt = {shreg, din};
   assign f_cmd     = frame_nxt[FRAME_W-1 -: CMD_W];
   assign f_addr    = frame_nxt[DATA_W +: ADDR_W];
   assign f_data    = frame_nxt[DATA_W-1:0];
   assign last_bit  = (cnt == CNT_W'(FRAME_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
      end else begin
         sclk_prev <= sclk_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FR_SHIFT;
         cnt     <= '0;
         shreg   <= '0;
         bit_idx <= BIT_W'(DATA_W - 1);
         rd_addr <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         dout    <= 1'b0;
         doe     <= 1'b0;
      end else if (!sel) begin
         st      <= FR_SHIFT;
         cnt     <= '0;
         bit_idx <= BIT_W'(DATA_W - 1);
         wr_en   <= 1'b0;
         dout    <= 1'b0;
         doe     <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         unique case (st)
            FR_SHIFT: begin
               if (rise) begin
                  shreg <= frame_nxt[FRAME_W-2:0];
                  cnt   <= cnt + 1'b1;
                  if (last_bit) begin
                     if (f_cmd == WR_CODE) begin
                        wr_en   <= 1'b1;
                        wr_addr <= f_addr;
                        wr_data <= f_data;
                        st      <= FR_DONE;
                     end else if (f_cmd == RD_CODE) begin
                        rd_addr <= f_addr;
                        bit_idx <= BIT_W'(DATA_W - 1);
                        st      <= FR_READ;
                     end else begin
                        st <= FR_DONE;
                     end
                  end
               end
            end
            FR_READ: begin
               if (fall) begin
                  dout    <= rd_data[bit_idx];
                  doe     <= 1'b1;
                  bit_idx <= (bit_idx == '0) ? BIT_W'(DATA_W - 1) : bit_idx - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   AST_WR_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(rise) && $past(cnt) == CNT_W'(FRAME_W - 1) && $past(sel))); // R3

   AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      doe |-> !wr_en); // R6

   AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel) && $past(doe) && !$past(fall)) |-> $stable(dout)); // R4

   AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(doe) |-> $past(st) == FR_READ); // R7

endmodule

// File: rtl/sreg_port.sv
module sreg_port
   import sreg_pkg::*;
#(
   parameter int unsigned CMD_W       = 4,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OSC_ADDR    = 3,
   parameter int unsigned XTAL_KHZ    = 13560,
   parameter int unsigned REF_KHZ     = 100,
   parameter logic [CMD_W-1:0] WR_CODE = CMD_WRITE,
   parameter logic [CMD_W-1:0] RD_CODE = CMD_READ
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cs_n,
   input  logic                          sclk,
   input  logic                          dio_i,
   output logic                          dio_o,
   output logic                          dio_oe,
   output logic [(DATA_W<<ADDR_W)-1:0]   reg_flat
);

   localparam int unsigned OSC_DIV = round_div(XTAL_KHZ, REF_KHZ);

   generate
      if (OSC_DIV >= (1 << DATA_W)) begin : g_bad_div
         $error("oscillator divisor does not fit the register width");
      end
      if (CMD_W != 4) begin : g_bad_cmd
         $error("command field is fixed at four bits");
      end
   endgenerate

   logic [2:0]        pins_q;
   logic              cs_q, sclk_q, din_q;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              wr_en;

   sreg_sync #(
      .STAGES (SYNC_STAGES),
      .W      (3),
      .RST_VAL(3'b101)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({dio_i, sclk, cs_n}),
      .q    (pins_q)
   );

   assign cs_q   = pins_q[0];
   assign sclk_q = pins_q[1];
   assign din_q  = pins_q[2];

   sreg_frame #(
      .CMD_W  (CMD_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .WR_CODE(WR_CODE),
      .RD_CODE(RD_CODE)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (~cs_q),
      .sclk_lvl(sclk_q),
      .din     (din_q),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .dout    (dio_o),
      .doe     (dio_oe)
   );

   sreg_file #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .OSC_ADDR(OSC_ADDR),
      .OSC_RST (DATA_W'(OSC_DIV))
   ) u_file (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .regs_flat(reg_flat)
   );

   AST_RELEASE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |=> !dio_oe); // R6

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs_q) && cs_q) |-> $stable(reg_flat)); // R9

endmodule

// File: tb/sreg_port_tb_top.sv
module sreg_port_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         sclk = 1'b0;
   logic         host_en = 1'b0;
   logic         host_bit = 1'b1;
   logic         dio_pad;
   logic         dio_o, dio_oe;
   logic [127:0] reg_flat;

   int total = 0;
   int bad   = 0;

   logic [7:0] model [16];
   bit         exp_q [$];
   string      tag_q [$];
   event       smp;

   always #4 clk = ~clk;

   assign dio_pad = dio_oe ? dio_o : (host_en ? host_bit : 1'b1);

   sreg_port dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .sclk    (sclk),
      .dio_i   (dio_pad),
      .dio_o   (dio_o),
      .dio_oe  (dio_oe),
      .reg_flat(reg_flat)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] model_flat();
      logic [127:0] f;
      for (int r = 0; r < 16; r++) f[r*8 +: 8] = model[r];
      return f;
   endfunction

   // scoreboard monitor: pops expected readback bits
   always @(smp) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " dio_o"}, {127'b0, dio_o}, {127'b0, e});
      check("R6 oe in readback", {127'b0, dio_oe}, 128'd1);
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b);
      host_en  = 1'b1;
      host_bit = b;
      wait_clk(8);
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
   endtask

   task automatic open_frame();
      cs_n = 1'b0;
      wait_clk(4);
   endtask

   task automatic close_frame();
      wait_clk(4);
      host_en = 1'b0;
      cs_n    = 1'b1;
      wait_clk(8);
      check("R6 released after deselect", {127'b0, dio_oe}, 128'd0);
   endtask

   task automatic send_bits(input logic [15:0] w, input int n);
      for (int i = 0; i < n; i++) clk_bit(w[15-i]);
   endtask

   task automatic do_write(input logic [3:0] a, input logic [7:0] d);
      open_frame();
      send_bits({4'b0001, a, d}, 16);
      check("R6 no drive in write", {127'b0, dio_oe}, 128'd0);
      close_frame();
      model[a] = d;
      check("R2 write stored", reg_flat, model_flat());
   endtask

   task automatic do_read(input logic [3:0] a, input int nbytes, input string tag);
      logic [15:0] w;
      w = {4'b0010, a, 8'h00};
      open_frame();
      send_bits(w, 15);
      host_bit = w[0];
      wait_clk(8);
      sclk = 1'b1;
      wait_clk(8);
      check("R6 no drive before turnaround", {127'b0, dio_oe}, 128'd0);
      sclk = 1'b0;
      host_en = 1'b0;
      for (int b = 0; b < nbytes; b++) begin
         for (int i = 7; i >= 0; i--) begin
            wait_clk(8);
            exp_q.push_back(model[a][i]);
            tag_q.push_back((b == 0) ? tag : "R5 repeat");
            ->smp;
            #1;
            sclk = 1'b1;
            wait_clk(8);
            sclk = 1'b0;
         end
      end
      close_frame();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int r = 0; r < 16; r++) model[r] = 8'h00;
      model[3] = 8'h88;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      check("R1 reset bank", reg_flat, model_flat());
      check("R1 reset no drive", {127'b0, dio_oe}, 128'd0);
      do_read(4'h3, 1, "R1 R4 divisor readback");

      do_write(4'h0, 8'h5A);
      do_write(4'hF, 8'hC3);
      do_write(4'h3, 8'h01);
      do_read(4'hF, 2, "R4 read high reg");
      do_read(4'h3, 3, "R4 read divisor reg");
      do_read(4'h0, 1, "R4 read reg0");

      // R3: truncated write
      open_frame();
      send_bits({4'b0001, 4'h5, 8'hEE}, 10);
      close_frame();
      check("R3 truncated frame discarded", reg_flat, model_flat());
      do_write(4'h5, 8'h77);
      check("R3 realigned write", {120'b0, reg_flat[47:40]}, 128'h77);

      // R7: unknown commands
      open_frame();
      send_bits({4'b0111, 4'h2, 8'hFF}, 16);
      send_bits(16'hFF00, 8);
      check("R7 unknown no drive", {127'b0, dio_oe}, 128'd0);
      close_frame();
      check("R7 unknown no change", reg_flat, model_flat());
      open_frame();
      send_bits({4'b0000, 4'h0, 8'hFF}, 16);
      close_frame();
      check("R7 zero cmd no change", reg_flat, model_flat());

      // R8: extra clocks after write
      open_frame();
      send_bits({4'b0001, 4'h6, 8'h12}, 16);
      send_bits({4'b0001, 4'h7, 8'h34}, 16);
      close_frame();
      model[6] = 8'h12;
      check("R8 extra clocks ignored", reg_flat, model_flat());

      // R9: clocks with select high
      host_en = 1'b1;
      for (int i = 0; i < 16; i++) begin
         host_bit = (i == 3) || (i >= 8);
         wait_clk(8);
         sclk = 1'b1;
         wait_clk(8);
         sclk = 1'b0;
      end
      host_en = 1'b0;
      wait_clk(8);
      check("R9 deselected clocks ignored", reg_flat, model_flat());
      check("R9 deselected no drive", {127'b0, dio_oe}, 128'd0);
      do_read(4'h6, 1, "R9 R4 read after idle clocks");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule